// File: doc/BRIEF.md
# Dual-Port Block RAM with Per-Port Write Modes

This block is a behavioural, synthesizable model of a true dual-port synchronous memory of 1024 words of 9 bits. Two ports, A and B, each have a clock, a clock enable, a write enable, a read-clear input, a 13-bit address, write data and a registered read output. Both ports can read and write. Each port chooses its own data width (1, 2, 4 or 9 bits) by parameter, so one port can, for example, write whole words while the other reads single bits of the same storage.

Each port also chooses, by parameter, what its read register shows on a cycle in which that port writes. It can keep its previous value, show the new data, or show the contents from before the write. A shared parameter selects whether the read-clear inputs act at the next clock edge or at once.

The address splits into a 10-bit word index (bits 12:3) and a 3-bit lane select (bits 2:0). Narrow ports use the lane select to pick a slice from the low eight bits of a word. Bit 8 of a word can be reached only through a 9-bit port. If both ports write the same 9-bit word on the same edge, the stored result is undefined.

Top module: `twin_port_ram`

## Requirements
- R1: For a port of width w in {1, 2, 4}, the word index is addr[12:3]. The slice is word bits [off+w-1:off], where off is addr[2:0] with its low log2(w) bits cleared. Address bits below log2(w) are ignored.
- R2: A 9-bit port reads and writes all nine bits of word addr[12:3], and it ignores addr[2:0], including the lowest bit.
- R3: A write from a narrow port leaves bit 8 of the word unchanged. Bit 8 is written and read only by a 9-bit port.
- R4: Data written by one port can be read by the other port through that port's own width mapping, on any later edge.
- R5: A read (ce high, we low) loads the selected data into the read register on the rising edge. The output does not change before that edge.
- R6: With ce low, a rising edge writes nothing and the read register keeps its value.
- R7: Write mode 0 (hold): on an enabled write edge, the writing port's read output keeps its previous value.
- R8: Write mode 1 (new): on an enabled write edge, the writing port's read output takes the data being written.
- R9: Write mode 2 (old): on an enabled write edge, the writing port's read output takes the slice contents from before the write.
- R10: With ASYNC_CLR = 0, a high clear input zeroes the read register at the rising edge, whatever the state of ce. No read is loaded on that edge, and a write enabled on that edge still takes place.
- R11: With ASYNC_CLR = 1, a high clear input zeroes the read register at once, with no clock edge. The register stays zero until the first enabled edge after the clear falls.
- R12: When both ports share a clock, a read of a word that the other port writes on the same edge returns the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock, rising edge |
| ce_a | input | 1 | Port A clock enable |
| we_a | input | 1 | Port A write enable |
| clr_a | input | 1 | Port A read-register clear |
| addr_a | input | 13 | Port A address |
| wdata_a | input | WIDTH_A | Port A write data |
| rdata_a | output | WIDTH_A | Port A registered read data |
| clk_b | input | 1 | Port B clock, rising edge |
| ce_b | input | 1 | Port B clock enable |
| we_b | input | 1 | Port B write enable |
| clr_b | input | 1 | Port B read-register clear |
| addr_b | input | 13 | Port B address |
| wdata_b | input | WIDTH_B | Port B write data |
| rdata_b | output | WIDTH_B | Port B registered read data |

## Verification
The bound assertions check four things on every edge of each port. A disabled port holds its output. A port in hold mode keeps its output across its own writes. A port in new-data mode shows exactly the written value. The configured clear style forces the output to zero. Several behaviours can only be shown by the bench's scenarios, because the property would need a model of the storage: the lane mapping across mixed widths, the survival of bit 8 under narrow writes, the old-data result of mode 2, the immediate effect of an asynchronous clear between edges, and the same-edge read of a word being written by the other port.

// File: rtl/tpr_pkg.sv
`timescale 1ns/1ps
package tpr_pkg;
  localparam int unsigned AW    = 13;            // address bits per port
  localparam int unsigned CW    = 9;             // storage word width
  localparam int unsigned SEL_W = 3;             // lane-select bits
  localparam int unsigned IDX_W = AW - SEL_W;    // word-index bits
  localparam int unsigned DEPTH = 1 << IDX_W;    // words in storage

  typedef enum logic [1:0] {
    WM_HOLD = 2'd0,
    WM_NEW  = 2'd1,
    WM_OLD  = 2'd2
  } wmode_e;

  function automatic logic [IDX_W-1:0] word_of(input logic [AW-1:0] addr);
    return addr[AW-1:SEL_W];
  endfunction

  // Bit offset of the slice a narrow port addresses inside a word.
  function automatic int unsigned lane_off(input logic [AW-1:0] addr,
                                           input int unsigned w);
    int unsigned raw;
    raw = 32'(addr[SEL_W-1:0]);
    if (w >= CW) return 0;
    return raw - (raw % w);
  endfunction

  function automatic logic [CW-1:0] lane_mask(input int unsigned w);
    return (CW'(1) << w) - CW'(1);
  endfunction

  function automatic logic [CW-1:0] get_lane(input logic [CW-1:0] word,
                                             input logic [AW-1:0] addr,
                                             input int unsigned w);
    if (w >= CW) return word;
    return (word >> lane_off(addr, w)) & lane_mask(w);
  endfunction

  function automatic logic [CW-1:0] put_lane(input logic [CW-1:0] word,
                                             input logic [AW-1:0] addr,
                                             input int unsigned w,
                                             input logic [CW-1:0] data);
    logic [CW-1:0] m;
    int unsigned   off;
    if (w >= CW) return data;
    off = lane_off(addr, w);
    m   = lane_mask(w) << off;
    return (word & ~m) | ((data << off) & m);
  endfunction
endpackage

// File: rtl/tpr_port.sv
`timescale 1ns/1ps
module tpr_port import tpr_pkg::*; #(
  parameter int unsigned WIDTH     = 9,
  parameter wmode_e      MODE      = WM_HOLD,
  parameter bit          ASYNC_CLR = 1'b0
) (
  input  logic             clk,
  input  logic             ce,
  input  logic             we,
  input  logic             clr,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [CW-1:0]    cur_word,
  output logic [IDX_W-1:0] word_idx,
  output logic             wr_fire,
  output logic [CW-1:0]    new_word,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] q;
  logic             load;
  logic [WIDTH-1:0] load_val;

  assign word_idx = word_of(addr);
  assign wr_fire  = ce & we;
  assign new_word = put_lane(cur_word, addr, WIDTH, CW'(wdata));

  always_comb begin
    load     = ce;
    load_val = WIDTH'(get_lane(cur_word, addr, WIDTH));
    if (ce && we) begin
      case (MODE)
        WM_HOLD: load     = 1'b0;
        WM_NEW:  load_val = wdata;
        default: load_val = WIDTH'(get_lane(cur_word, addr, WIDTH));
      endcase
    end
  end

  if (ASYNC_CLR) begin : g_async
    always_ff @(posedge clk or posedge clr)
      if (clr)       q <= '0;
      else if (load) q <= load_val;
  end else begin : g_sync
    always_ff @(posedge clk)
      if (clr)       q <= '0;
      else if (load) q <= load_val;
  end

  assign rdata = q;
endmodule

// File: rtl/tpr_store.sv
`timescale 1ns/1ps
module tpr_store import tpr_pkg::*; (
  input  logic             clk_a,
  input  logic             fire_a,
  input  logic [IDX_W-1:0] idx_a,
  input  logic [CW-1:0]    word_a,
  input  logic             clk_b,
  input  logic             fire_b,
  input  logic [IDX_W-1:0] idx_b,
  input  logic [CW-1:0]    word_b,
  output logic [CW-1:0]    cur_a,
  output logic [CW-1:0]    cur_b
);
  // Two banks, each written by one port only; the stored word is their XOR.
  logic [CW-1:0] bank_a [DEPTH];
  logic [CW-1:0] bank_b [DEPTH];

  always_ff @(posedge clk_a)
    if (fire_a) bank_a[idx_a] <= word_a ^ bank_b[idx_a];

  always_ff @(posedge clk_b)
    if (fire_b) bank_b[idx_b] <= word_b ^ bank_a[idx_b];

  assign cur_a = bank_a[idx_a] ^ bank_b[idx_a];
  assign cur_b = bank_a[idx_b] ^ bank_b[idx_b];
endmodule

// File: rtl/twin_port_ram.sv
`timescale 1ns/1ps
module twin_port_ram import tpr_pkg::*; #(
  parameter int unsigned WIDTH_A   = 9,
  parameter int unsigned WIDTH_B   = 9,
  parameter wmode_e      MODE_A    = WM_HOLD,
  parameter wmode_e      MODE_B    = WM_HOLD,
  parameter bit          ASYNC_CLR = 1'b0
) (
  input  logic               clk_a,
  input  logic               ce_a,
  input  logic               we_a,
  input  logic               clr_a,
  input  logic [AW-1:0]      addr_a,
  input  logic [WIDTH_A-1:0] wdata_a,
  output logic [WIDTH_A-1:0] rdata_a,
  input  logic               clk_b,
  input  logic               ce_b,
  input  logic               we_b,
  input  logic               clr_b,
  input  logic [AW-1:0]      addr_b,
  input  logic [WIDTH_B-1:0] wdata_b,
  output logic [WIDTH_B-1:0] rdata_b
);
  logic [IDX_W-1:0] idx_a, idx_b;
  logic             fire_a, fire_b;
  logic [CW-1:0]    new_a, new_b;
  logic [CW-1:0]    cur_a, cur_b;

  tpr_port #(.WIDTH(WIDTH_A), .MODE(MODE_A), .ASYNC_CLR(ASYNC_CLR)) u_port_a (
    .clk(clk_a), .ce(ce_a), .we(we_a), .clr(clr_a), .addr(addr_a),
    .wdata(wdata_a), .cur_word(cur_a), .word_idx(idx_a), .wr_fire(fire_a),
    .new_word(new_a), .rdata(rdata_a)
  );

  tpr_port #(.WIDTH(WIDTH_B), .MODE(MODE_B), .ASYNC_CLR(ASYNC_CLR)) u_port_b (
    .clk(clk_b), .ce(ce_b), .we(we_b), .clr(clr_b), .addr(addr_b),
    .wdata(wdata_b), .cur_word(cur_b), .word_idx(idx_b), .wr_fire(fire_b),
    .new_word(new_b), .rdata(rdata_b)
  );

  tpr_store u_store (
    .clk_a(clk_a), .fire_a(fire_a), .idx_a(idx_a), .word_a(new_a),
    .clk_b(clk_b), .fire_b(fire_b), .idx_b(idx_b), .word_b(new_b),
    .cur_a(cur_a), .cur_b(cur_b)
  );
endmodule

// File: rtl/tpr_checker.sv
`timescale 1ns/1ps
module tpr_checker import tpr_pkg::*; #(
  parameter int unsigned WIDTH_A   = 9,
  parameter int unsigned WIDTH_B   = 9,
  parameter wmode_e      MODE_A    = WM_HOLD,
  parameter wmode_e      MODE_B    = WM_HOLD,
  parameter bit          ASYNC_CLR = 1'b0
) (
  input logic               clk_a,
  input logic               ce_a,
  input logic               clr_a,
  input logic               fire_a,
  input logic [WIDTH_A-1:0] wdata_a,
  input logic [WIDTH_A-1:0] rdata_a,
  input logic               clk_b,
  input logic               ce_b,
  input logic               clr_b,
  input logic               fire_b,
  input logic [WIDTH_B-1:0] wdata_b,
  input logic [WIDTH_B-1:0] rdata_b
);
  AST_A_CE_GATED: assert property (@(posedge clk_a) disable iff (clr_a) !ce_a |=> $stable(rdata_a)); // R6
  AST_B_CE_GATED: assert property (@(posedge clk_b) disable iff (clr_b) !ce_b |=> $stable(rdata_b)); // R6
  AST_A_HOLD_MODE: assert property (@(posedge clk_a) disable iff (clr_a) (fire_a && MODE_A == WM_HOLD) |=> $stable(rdata_a)); // R7
  AST_B_HOLD_MODE: assert property (@(posedge clk_b) disable iff (clr_b) (fire_b && MODE_B == WM_HOLD) |=> $stable(rdata_b)); // R7
  AST_A_NEW_MODE: assert property (@(posedge clk_a) disable iff (clr_a) (fire_a && MODE_A == WM_NEW) |=> rdata_a == $past(wdata_a)); // R8
  AST_B_NEW_MODE: assert property (@(posedge clk_b) disable iff (clr_b) (fire_b && MODE_B == WM_NEW) |=> rdata_b == $past(wdata_b)); // R8
  AST_A_SYNC_CLEAR: assert property (@(posedge clk_a) (clr_a && !ASYNC_CLR) |=> rdata_a == '0); // R10
  AST_B_SYNC_CLEAR: assert property (@(posedge clk_b) (clr_b && !ASYNC_CLR) |=> rdata_b == '0); // R10
  AST_A_ASYNC_CLEAR: assert property (@(posedge clk_a) (clr_a && ASYNC_CLR) |-> rdata_a == '0); // R11
  AST_B_ASYNC_CLEAR: assert property (@(posedge clk_b) (clr_b && ASYNC_CLR) |-> rdata_b == '0); // R11
endmodule

bind twin_port_ram tpr_checker #(
  .WIDTH_A(WIDTH_A), .WIDTH_B(WIDTH_B), .MODE_A(MODE_A), .MODE_B(MODE_B),
  .ASYNC_CLR(ASYNC_CLR)
) u_tpr_checker (
  .clk_a(clk_a), .ce_a(ce_a), .clr_a(clr_a), .fire_a(fire_a),
  .wdata_a(wdata_a), .rdata_a(rdata_a),
  .clk_b(clk_b), .ce_b(ce_b), .clr_b(clr_b), .fire_b(fire_b),
  .wdata_b(wdata_b), .rdata_b(rdata_b)
);

// File: tb/twin_port_ram_bench.sv
`timescale 1ns/1ps
module twin_port_ram_bench;
  import tpr_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;   // 100 MHz

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // Instance 1: A 9-bit hold mode, B 2-bit new-data mode, synchronous clear
  logic        x1_ce_a, x1_we_a, x1_clr_a, x1_ce_b, x1_we_b, x1_clr_b;
  logic [12:0] x1_addr_a, x1_addr_b;
  logic [8:0]  x1_wd_a, x1_rd_a;
  logic [1:0]  x1_wd_b, x1_rd_b;

  twin_port_ram #(.WIDTH_A(9), .WIDTH_B(2), .MODE_A(WM_HOLD), .MODE_B(WM_NEW),
                  .ASYNC_CLR(1'b0)) u_twin_port_ram (
    .clk_a(clk), .ce_a(x1_ce_a), .we_a(x1_we_a), .clr_a(x1_clr_a),
    .addr_a(x1_addr_a), .wdata_a(x1_wd_a), .rdata_a(x1_rd_a),
    .clk_b(clk), .ce_b(x1_ce_b), .we_b(x1_we_b), .clr_b(x1_clr_b),
    .addr_b(x1_addr_b), .wdata_b(x1_wd_b), .rdata_b(x1_rd_b)
  );

  // Instance 2: A 4-bit old-data mode, B 1-bit hold mode, asynchronous clear
  logic        x2_ce_a, x2_we_a, x2_clr_a, x2_ce_b, x2_we_b, x2_clr_b;
  logic [12:0] x2_addr_a, x2_addr_b;
  logic [3:0]  x2_wd_a, x2_rd_a;
  logic [0:0]  x2_wd_b, x2_rd_b;

  twin_port_ram #(.WIDTH_A(4), .WIDTH_B(1), .MODE_A(WM_OLD), .MODE_B(WM_HOLD),
                  .ASYNC_CLR(1'b1)) u_twin_port_ram_alt (
    .clk_a(clk), .ce_a(x2_ce_a), .we_a(x2_we_a), .clr_a(x2_clr_a),
    .addr_a(x2_addr_a), .wdata_a(x2_wd_a), .rdata_a(x2_rd_a),
    .clk_b(clk), .ce_b(x2_ce_b), .we_b(x2_we_b), .clr_b(x2_clr_b),
    .addr_b(x2_addr_b), .wdata_b(x2_wd_b), .rdata_b(x2_rd_b)
  );

  typedef struct packed {
    logic        on_b;
    logic        we;
    logic [12:0] addr;
    logic [8:0]  data;
    logic [8:0]  exp;
  } vec_t;

  // Walk on instance 1; exp is the output of the active port after its edge.
  localparam vec_t TBL [10] = '{
    '{1'b0, 1'b1, 13'h028, 9'h1A5, 9'h000},  // R7 hold: A output stays 0
    '{1'b0, 1'b0, 13'h02F, 9'h000, 9'h1A5},  // R2 low address bits ignored
    '{1'b1, 1'b0, 13'h028, 9'h000, 9'h001},  // R4 R1 slice at offset 0
    '{1'b1, 1'b0, 13'h02D, 9'h000, 9'h002},  // R1 addr[0] ignored, offset 4
    '{1'b1, 1'b1, 13'h02E, 9'h001, 9'h001},  // R8 new data on B write
    '{1'b0, 1'b0, 13'h028, 9'h000, 9'h165},  // R3 bit 8 kept by narrow write
    '{1'b0, 1'b1, 13'h030, 9'h0FF, 9'h165},  // R7 hold on second write
    '{1'b1, 1'b0, 13'h031, 9'h000, 9'h003},  // R1 offset 0, addr[0] ignored
    '{1'b1, 1'b1, 13'h036, 9'h000, 9'h000},  // R8 new data zero
    '{1'b0, 1'b0, 13'h030, 9'h000, 9'h03F}   // R4 B write seen by A
  };

  task automatic chk(input string req, input string what,
                     input logic [8:0] got, input logic [8:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic idle1();
    x1_ce_a = 0; x1_we_a = 0; x1_ce_b = 0; x1_we_b = 0;
  endtask

  task automatic idle2();
    x2_ce_a = 0; x2_we_a = 0; x2_ce_b = 0; x2_we_b = 0;
  endtask

  task automatic op1(input logic on_b, input logic we,
                     input logic [12:0] addr, input logic [8:0] data);
    x1_ce_a = !on_b; x1_we_a = we & !on_b; x1_addr_a = addr; x1_wd_a = data;
    x1_ce_b = on_b;  x1_we_b = we & on_b;  x1_addr_b = addr; x1_wd_b = data[1:0];
    @(negedge clk);
  endtask

  task automatic op2(input logic on_b, input logic we,
                     input logic [12:0] addr, input logic [8:0] data);
    x2_ce_a = !on_b; x2_we_a = we & !on_b; x2_addr_a = addr; x2_wd_a = data[3:0];
    x2_ce_b = on_b;  x2_we_b = we & on_b;  x2_addr_b = addr; x2_wd_b = data[0:0];
    @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    idle1(); idle2();
    x1_addr_a = '0; x1_addr_b = '0; x1_wd_a = '0; x1_wd_b = '0;
    x2_addr_a = '0; x2_addr_b = '0; x2_wd_a = '0; x2_wd_b = '0;
    x1_clr_a = 1; x1_clr_b = 1; x2_clr_a = 1; x2_clr_b = 1;
    @(negedge clk); @(negedge clk);
    chk("R10", "reset A1", 9'(x1_rd_a), 9'h000);
    chk("R10", "reset B1", 9'(x1_rd_b), 9'h000);
    chk("R11", "reset A2", 9'(x2_rd_a), 9'h000);
    chk("R11", "reset B2", 9'(x2_rd_b), 9'h000);
    x1_clr_a = 0; x1_clr_b = 0; x2_clr_a = 0; x2_clr_b = 0;
    @(negedge clk);

    foreach (TBL[i]) begin
      op1(TBL[i].on_b, TBL[i].we, TBL[i].addr, TBL[i].data);
      if (TBL[i].on_b) chk("R1/R4/R8 table", $sformatf("row %0d B", i), 9'(x1_rd_b), TBL[i].exp);
      else             chk("R2/R3/R7 table", $sformatf("row %0d A", i), 9'(x1_rd_a), TBL[i].exp);
    end

    // R5: output changes only at the edge
    x1_ce_a = 1; x1_we_a = 0; x1_addr_a = 13'h028; x1_ce_b = 0; x1_we_b = 0;
    #2 chk("R5", "before edge", 9'(x1_rd_a), 9'h03F);
    @(negedge clk);
    chk("R5", "after edge", 9'(x1_rd_a), 9'h165);

    // R6: disabled write is dropped and output holds
    idle1(); x1_we_a = 1; x1_addr_a = 13'h028; x1_wd_a = 9'h000;
    @(negedge clk);
    chk("R6", "ce low holds", 9'(x1_rd_a), 9'h165);
    op1(0, 0, 13'h028, 9'h000);
    chk("R6", "ce low no write", 9'(x1_rd_a), 9'h165);

    // R10: synchronous clear, ce low
    idle1(); x1_clr_a = 1;
    #2 chk("R10", "no clear before edge", 9'(x1_rd_a), 9'h165);
    @(negedge clk);
    chk("R10", "clear at edge", 9'(x1_rd_a), 9'h000);
    // R10: clear together with a write; write still lands
    x1_clr_a = 1;
    op1(0, 1, 13'h040, 9'h123);
    chk("R10", "clear wins read", 9'(x1_rd_a), 9'h000);
    x1_clr_a = 0;
    op1(0, 0, 13'h040, 9'h000);
    chk("R10", "write during clear", 9'(x1_rd_a), 9'h123);

    // R12: same-edge read of a word the other port writes
    op1(0, 1, 13'h050, 9'h011);
    x1_ce_a = 1; x1_we_a = 1; x1_addr_a = 13'h050; x1_wd_a = 9'h0AA;
    x1_ce_b = 1; x1_we_b = 0; x1_addr_b = 13'h050;
    @(negedge clk);
    chk("R12", "old contents", 9'(x1_rd_b), 9'h001);
    op1(1, 0, 13'h050, 9'h000);
    chk("R12", "new contents after", 9'(x1_rd_b), 9'h002);
    idle1();

    // Instance 2: R9 old-data mode on 4-bit port
    op2(0, 1, 13'h100, 9'h003);
    op2(0, 1, 13'h104, 9'h005);
    op2(0, 1, 13'h100, 9'h009);
    chk("R9", "old lane 0", 9'(x2_rd_a), 9'h003);
    op2(0, 1, 13'h103, 9'h006);
    chk("R9", "old lane, addr[1:0] ignored", 9'(x2_rd_a), 9'h009);
    op2(0, 0, 13'h104, 9'h000);
    chk("R1", "upper nibble", 9'(x2_rd_a), 9'h005);
    op2(1, 0, 13'h101, 9'h000);
    chk("R4", "bit 1 via 1-bit port", 9'(x2_rd_b), 9'h001);
    op2(1, 1, 13'h107, 9'h001);
    chk("R7", "hold on 1-bit write", 9'(x2_rd_b), 9'h001);
    op2(1, 0, 13'h103, 9'h000);
    chk("R1", "bit 3", 9'(x2_rd_b), 9'h000);
    op2(0, 0, 13'h104, 9'h000);
    chk("R4", "bit 7 seen by 4-bit port", 9'(x2_rd_a), 9'h00D);

    // R11: asynchronous clear
    idle2(); x2_clr_a = 1;
    #1 chk("R11", "immediate clear", 9'(x2_rd_a), 9'h000);
    @(negedge clk);
    op2(0, 0, 13'h104, 9'h000);
    chk("R11", "read blocked by clear", 9'(x2_rd_a), 9'h000);
    x2_clr_a = 0; idle2();
    @(negedge clk);
    chk("R11", "zero after release", 9'(x2_rd_a), 9'h000);
    op2(0, 0, 13'h104, 9'h000);
    chk("R11", "read resumes", 9'(x2_rd_a), 9'h00D);
    idle2();

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end
endmodule